// File: doc/BRIEF.md
# Raster Timing Generator with Pixel Doubling

The block produces the line and frame timing for a 640 by 480 display with 8-bit colour samples. It runs from one pixel-rate clock of 25.000 MHz, a little slower than the nominal 25.175 MHz rate, and keeps the standard cycle counts for each timing phase. Every line steps through four phases in a fixed order: visible pixels, front porch, sync pulse and back porch. Every frame steps through the same four phases, counted in lines. The block drives both sync outputs, a visible-region flag, and the column and row that the framebuffer fetch logic should read.

A doubling input selects one of two addressing modes. In native mode the column and row equal the physical position. In doubled mode both are halved, so each stored pixel is shown twice and each stored line is read twice. This gives 320 by 240 addressing while the display still receives all 480 physical lines. A blank output tells memory-write logic when the fetch side is idle, so that writes can be deferred to that window.

All outputs come from registers, which keeps decode glitches off the sync lines. Each output reflects the counter position of the previous clock cycle. Some monitors lock only when the horizontal sync is inverted, so the polarity of each sync is selectable.

Top module: `vga_raster_gen`

## Requirements
- R1: A line lasts 800 clocks. The first 640 positions are visible, followed by 16 front porch, 96 sync and 48 back porch positions, in that order.
- R2: The horizontal sync is asserted for line positions 656 through 751 inclusive and deasserted at every other position.
- R3: A frame lasts 525 lines: 480 visible, 10 front porch, 2 sync and 33 back porch. The vertical sync is asserted for lines 490 and 491 only.
- R4: The line count advances by exactly one when the line position wraps from 799 to 0, and it holds at every other cycle.
- R5: `blank_o` is 1 exactly when the position lies outside the visible 640 by 480 region, and `active_o` is its complement.
- R6: With `dbl_i` = 1, `col_o` and `row_o` are the physical line position and line count shifted right by one bit. With `dbl_i` = 0 they equal the physical values. Outside the visible region both are 0.
- R7: With `hs_pol_i` = 0 the asserted horizontal sync level is 0, and with `hs_pol_i` = 1 it is 1. `vs_pol_i` selects the vertical sync level in the same way.
- R8: While `rst_n` is low, `hsync_o` and `vsync_o` are 1, `active_o` is 0, `blank_o` is 1, and `col_o` and `row_o` are 0.
- R9: The outputs are registered. After the first clock edge with `rst_n` high, they describe position (0,0). After edge k they describe position k-1, counted over 800 positions per line and 525 lines per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbl_i | input | 1 | 1 selects doubled (halved-coordinate) addressing |
| hs_pol_i | input | 1 | Asserted level of the horizontal sync |
| vs_pol_i | input | 1 | Asserted level of the vertical sync |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| active_o | output | 1 | High inside the visible region |
| blank_o | output | 1 | High outside the visible region (idle window for memory writes) |
| col_o | output | 10 | Framebuffer read column |
| row_o | output | 9 | Framebuffer read row |

## Verification
The bench aims at the phase boundaries: the last visible pixel, the first and last sync positions, and the wrap of the line count. A design that is off by one at any of these points shows up as a sync pulse that is one clock too long or starts one clock late, or as a visible line that is one pixel short. The bench also toggles doubling and polarity at random between cycles. A design that reads these inputs combinationally at its outputs, or that halves the count with the wrong bit slice, then produces wrong coordinates or wrong sync levels. A second instance with a tiny raster runs through hundreds of frames, so that a line count which advances on the wrong cycle or fails to wrap at the end of a frame is caught quickly.

// File: rtl/vga_raster_pkg.sv
package vga_raster_pkg;

    // Decoded phase of one timing axis for the current count
    typedef struct packed {
        logic visible;
        logic sync;
        logic last;
    } axis_phase_t;

endpackage

// File: rtl/vga_axis_ctr.sv
module vga_axis_ctr
    import vga_raster_pkg::*;
#(
    parameter int ACTIVE = 640,
    parameter int FP     = 16,
    parameter int SYNC   = 96,
    parameter int BP     = 48,
    localparam int TOTAL = ACTIVE + FP + SYNC + BP,
    localparam int CW    = $clog2(TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    output logic [CW-1:0] cnt_o,
    output axis_phase_t   phase_o
);

    localparam logic [CW-1:0] VIS_END  = CW'(ACTIVE);
    localparam logic [CW-1:0] SYNC_LO  = CW'(ACTIVE + FP);
    localparam logic [CW-1:0] SYNC_HI  = CW'(ACTIVE + FP + SYNC);
    localparam logic [CW-1:0] LAST_POS = CW'(TOTAL - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        phase_o.visible = (cnt_q < VIS_END);
        phase_o.sync    = (cnt_q >= SYNC_LO) && (cnt_q < SYNC_HI);
        phase_o.last    = (cnt_q == LAST_POS);
        cnt_d = cnt_q;
        if (step_i) begin
            cnt_d = phase_o.last ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R1
    in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_POS);

    // R4
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && cnt_q == LAST_POS) |=> (cnt_q == '0));

    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(cnt_q));

endmodule

// File: rtl/vga_coord_map.sv
module vga_coord_map #(
    parameter int IN_W  = 10,
    parameter int OUT_W = 10
) (
    input  logic [IN_W-1:0]  cnt_i,
    input  logic             dbl_i,
    input  logic             vis_i,
    output logic [OUT_W-1:0] coord_o
);

    logic [IN_W-1:0]  pick;
    logic [OUT_W-1:0] sized;

    always_comb begin
        pick = dbl_i ? (cnt_i >> 1) : cnt_i;
    end

    generate
        if (OUT_W < IN_W) begin : g_trunc
            assign sized = pick[OUT_W-1:0];
        end else if (OUT_W == IN_W) begin : g_same
            assign sized = pick;
        end else begin : g_ext
            assign sized = {{(OUT_W-IN_W){1'b0}}, pick};
        end
    endgenerate

    assign coord_o = vis_i ? sized : '0;

endmodule

// File: rtl/vga_raster_gen.sv
module vga_raster_gen
    import vga_raster_pkg::*;
#(
    parameter int H_ACTIVE = 640,
    parameter int H_FP     = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BP     = 48,
    parameter int V_ACTIVE = 480,
    parameter int V_FP     = 10,
    parameter int V_SYNC   = 2,
    parameter int V_BP     = 33,
    localparam int CXW     = $clog2(H_ACTIVE),
    localparam int RYW     = $clog2(V_ACTIVE)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dbl_i,
    input  logic           hs_pol_i,
    input  logic           vs_pol_i,
    output logic           hsync_o,
    output logic           vsync_o,
    output logic           active_o,
    output logic           blank_o,
    output logic [CXW-1:0] col_o,
    output logic [RYW-1:0] row_o
);

    localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
    localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
    localparam int HW      = $clog2(H_TOTAL);
    localparam int VW      = $clog2(V_TOTAL);

    typedef struct packed {
        logic           hs_on;
        logic           vs_on;
        logic           dbl;
        logic           hsync;
        logic           vsync;
        logic           active;
        logic           blank;
        logic [CXW-1:0] col;
        logic [RYW-1:0] row;
    } out_t;

    localparam out_t OUT_RST = '{hs_on: 1'b0, vs_on: 1'b0, dbl: 1'b0,
                                 hsync: 1'b1, vsync: 1'b1, active: 1'b0,
                                 blank: 1'b1, col: '0, row: '0};

    logic [HW-1:0]  h_cnt;
    logic [VW-1:0]  v_cnt;
    axis_phase_t    h_ph, v_ph;
    logic           vis;
    logic [CXW-1:0] col_map;
    logic [RYW-1:0] row_map;
    out_t           out_d, out_q;

    vga_axis_ctr #(.ACTIVE(H_ACTIVE), .FP(H_FP), .SYNC(H_SYNC), .BP(H_BP)) u_hctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (1'b1),
        .cnt_o   (h_cnt),
        .phase_o (h_ph)
    );

    vga_axis_ctr #(.ACTIVE(V_ACTIVE), .FP(V_FP), .SYNC(V_SYNC), .BP(V_BP)) u_vctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (h_ph.last),
        .cnt_o   (v_cnt),
        .phase_o (v_ph)
    );

    assign vis = h_ph.visible & v_ph.visible;

    vga_coord_map #(.IN_W(HW), .OUT_W(CXW)) u_colmap (
        .cnt_i   (h_cnt),
        .dbl_i   (dbl_i),
        .vis_i   (vis),
        .coord_o (col_map)
    );

    vga_coord_map #(.IN_W(VW), .OUT_W(RYW)) u_rowmap (
        .cnt_i   (v_cnt),
        .dbl_i   (dbl_i),
        .vis_i   (vis),
        .coord_o (row_map)
    );

    always_comb begin
        out_d        = out_q;
        out_d.hs_on  = h_ph.sync;
        out_d.vs_on  = v_ph.sync;
        out_d.dbl    = dbl_i;
        out_d.hsync  = h_ph.sync ? hs_pol_i : ~hs_pol_i;
        out_d.vsync  = v_ph.sync ? vs_pol_i : ~vs_pol_i;
        out_d.active = vis;
        out_d.blank  = ~vis;
        out_d.col    = col_map;
        out_d.row    = row_map;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= OUT_RST;
        else        out_q <= out_d;
    end

    assign hsync_o  = out_q.hsync;
    assign vsync_o  = out_q.vsync;
    assign active_o = out_q.active;
    assign blank_o  = out_q.blank;
    assign col_o    = out_q.col;
    assign row_o    = out_q.row;

    // R2
    no_hsync_in_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.active |-> !out_q.hs_on);

    // R3
    no_vsync_in_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.active |-> !out_q.vs_on);

    // R5
    blank_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.blank != out_q.active);

    // R6
    half_col_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.active && out_q.dbl) |-> (int'(out_q.col) < (H_ACTIVE + 1) / 2));

    // R9
    col_follows_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_ph.visible && v_ph.visible && !dbl_i) |=> (int'(out_q.col) == int'($past(h_cnt))));

endmodule

// File: tb/tb_vga_raster_gen.sv
module tb_vga_raster_gen;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dbl = 1'b0, hp = 1'b0, vp = 1'b0;
    logic e_dbl, e_hp, e_vp;
    int   checks = 0, errors = 0, k = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    logic       hs_a, vs_a, act_a, blk_a;
    logic [9:0] col_a;
    logic [8:0] row_a;
    logic       hs_b, vs_b, act_b, blk_b;
    logic [1:0] col_b, row_b;

    vga_raster_gen dut (
        .clk(clk), .rst_n(rst_n), .dbl_i(dbl), .hs_pol_i(hp), .vs_pol_i(vp),
        .hsync_o(hs_a), .vsync_o(vs_a), .active_o(act_a), .blank_o(blk_a),
        .col_o(col_a), .row_o(row_a)
    );

    vga_raster_gen #(.H_ACTIVE(4), .H_FP(2), .H_SYNC(2), .H_BP(2),
                     .V_ACTIVE(3), .V_FP(1), .V_SYNC(1), .V_BP(2)) dut_small (
        .clk(clk), .rst_n(rst_n), .dbl_i(dbl), .hs_pol_i(hp), .vs_pol_i(vp),
        .hsync_o(hs_b), .vsync_o(vs_b), .active_o(act_b), .blank_o(blk_b),
        .col_o(col_b), .row_o(row_b)
    );

    task automatic chk(input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s at edge %0d: got %0d expected %0d", what, k, got, exp);
        end
    endtask

    task automatic check_raster(input string who, input int ha, input int hf, input int hs,
                                input int hb, input int va, input int vf, input int vs,
                                input int vb, input int g_hs, input int g_vs, input int g_act,
                                input int g_blk, input int g_col, input int g_row);
        int ht = ha + hf + hs + hb;
        int vt = va + vf + vs + vb;
        int p  = k - 1;
        int h  = p % ht;
        int v  = (p / ht) % vt;
        bit vis = (h < ha) && (v < va);
        bit hon = (h >= ha + hf) && (h < ha + hf + hs);
        bit von = (v >= va + vf) && (v < va + vf + vs);
        chk({who, " R1 R9 active"}, g_act, int'(vis));
        chk({who, " R5 blank"}, g_blk, int'(!vis));
        chk({who, " R2 R7 hsync"}, g_hs, int'(hon ? e_hp : !e_hp));
        chk({who, " R3 R7 vsync"}, g_vs, int'(von ? e_vp : !e_vp));
        chk({who, " R6 col"}, g_col, vis ? (e_dbl ? h >> 1 : h) : 0);
        chk({who, " R4 R6 row"}, g_row, vis ? (e_dbl ? v >> 1 : v) : 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        // R8 reset state on both instances
        chk("R8 hsync", int'(hs_a), 1);
        chk("R8 vsync", int'(vs_a), 1);
        chk("R8 active", int'(act_a), 0);
        chk("R8 blank", int'(blk_a), 1);
        chk("R8 col", int'(col_a), 0);
        chk("R8 row", int'(row_a), 0);
        chk("R8 small blank", int'(blk_b), 1);
        rst_n = 1'b1;
        for (int i = 0; i < 30000; i++) begin
            @(posedge clk);
            k++;
            e_dbl = dbl; e_hp = hp; e_vp = vp;
            @(negedge clk);
            check_raster("full", 640, 16, 96, 48, 480, 10, 2, 33,
                         int'(hs_a), int'(vs_a), int'(act_a), int'(blk_a),
                         int'(col_a), int'(row_a));
            check_raster("small", 4, 2, 2, 2, 3, 1, 1, 2,
                         int'(hs_b), int'(vs_b), int'(act_b), int'(blk_b),
                         int'(col_b), int'(row_b));
            if (i < 4000) begin
                dbl = 1'b0; hp = 1'b0; vp = 1'b0;
            end else if (i < 8000) begin
                dbl = 1'b1; hp = 1'b1; vp = 1'b1;
            end else begin
                dbl = 1'($urandom % 2);
                if ($urandom % 32 == 0) hp = ~hp;
                if ($urandom % 32 == 0) vp = ~vp;
            end
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule